// File: doc/BRIEF.md
# Circular Trace Buffer Fill Counter

This block keeps track of how much of a circular trace memory (64 lines, each 64 bits wide) holds valid capture data. A trace capture path offers 32-bit half-line words over a valid/ready stream. Each accepted word is steered to the line and half given by the running half-line count, so the block also produces the write strobe, line address and half select for the trace RAM. The RAM itself sits outside the block.

The count is kept in half-line units and is presented as an 8-bit read-only register. When the count wraps from its maximum back to zero, a full flag is set. In the overwrite alignments (end or mid trigger), capture then carries on and the newest words replace the oldest. In the begin-trigger alignment, the wrap disarms the block and raises a one-cycle session-end pulse. The count and the full flag survive a system reset and are cleared only by power-on reset or by arming a new session.

Stream rules: `hw_ready` is high only while the block is armed, no arm write is in progress and system reset is released. A word is taken on any clock edge where `hw_valid && hw_ready`. The source may hold `hw_valid` high for as long as it likes. A word offered while `hw_ready` is low is neither stored nor counted.

Top module: `trace_fill_counter`

## Requirements
- R1: Power-on reset (`por_n` low, asynchronous) clears the count, the full flag and the arm state. `count_reg` is 8 bits wide: bit 7 always reads 0 and bits 6:0 hold the half-line count.
- R2: A word is accepted only when `hw_valid && hw_ready`. `hw_ready` is low while disarmed, so words offered then have no effect. Each accepted word raises the count by exactly one.
- R3: During an accepted word, `ram_we` is high, `ram_addr` equals count bits 6:1, `ram_half` equals count bit 0 (1 = upper half) and `ram_wdata` equals `hw_data`.
- R4: An accepted word at count 127 takes the count to 0 and sets `buf_full`. A count of 0 with `buf_full` set means all 64 lines are valid.
- R5: With `align_mode` 2'b00 (end trigger) or 2'b01 (mid trigger), the value 2'b11 behaving as 2'b00, capture continues after the wrap. The line address wraps modulo 64 and the block stays armed.
- R6: With `align_mode` 2'b10 (begin trigger), the wrap clears the arm state. `session_end` goes high for exactly one cycle on the following cycle, and no further words are accepted.
- R7: An arm write with `arm_wdata` = 1 sets the arm state and clears both the count and `buf_full`. In a cycle with an arm write, `hw_ready` is low, so the clear takes priority over an offered word.
- R8: An arm write with `arm_wdata` = 0 disarms the block and leaves the count and `buf_full` unchanged.
- R9: System reset (`sys_rst_n` low, synchronous) clears only the arm state. The count and `buf_full` keep their values.
- R10: The count never decreases on its own and has no host write path. With no accepted word and no arm or power-on reset, the count and `buf_full` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| arm_wr | input | 1 | Write strobe for the arm control bit |
| arm_wdata | input | 1 | Value written to the arm control bit |
| align_mode | input | 2 | Trigger alignment: 00 end, 01 mid, 10 begin |
| hw_valid | input | 1 | Half-line word offered |
| hw_ready | output | 1 | Block can take a half-line word |
| hw_data | input | 32 | Half-line word |
| ram_we | output | 1 | Trace RAM write enable |
| ram_addr | output | 6 | Trace RAM line address |
| ram_half | output | 1 | Half select, 1 = upper 32 bits |
| ram_wdata | output | 32 | Data to trace RAM |
| count_reg | output | 8 | Read-only count register |
| buf_full | output | 1 | Count has wrapped since arming |
| armed | output | 1 | Arm state |
| session_end | output | 1 | One-cycle pulse when begin-trigger capture fills the buffer |

## Verification
A wrong count shows up on `count_reg` and on `ram_addr`/`ram_half` on the very next accepted word. A lost or spurious wrap appears at once on `buf_full` and, in begin-trigger alignment, on `armed` and `session_end` one cycle after the 128th word. A wrong arm state is visible on `hw_ready` in the same cycle. A count disturbed by system reset or by idle cycles is visible on `count_reg` the cycle after.

// File: rtl/trace_fill_pkg.sv
package trace_fill_pkg;
  typedef enum logic [1:0] {
    ALIGN_END   = 2'b00,
    ALIGN_MID   = 2'b01,
    ALIGN_BEGIN = 2'b10,
    ALIGN_RSVD  = 2'b11
  } align_e;

  function automatic logic stops_on_wrap(input logic [1:0] mode);
    return align_e'(mode) == ALIGN_BEGIN;
  endfunction
endpackage

// File: rtl/trace_half_counter.sv
module trace_half_counter #(
  parameter int LINES = 64
) (
  input  logic                        clk,
  input  logic                        por_n,
  input  logic                        clr,
  input  logic                        inc,
  output logic [$clog2(LINES):0]      cnt,
  output logic                        full,
  output logic                        wrap
);
  localparam int CNT_W = $clog2(LINES) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign wrap = inc && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
      if (wrap) full <= 1'b1;
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!por_n)
    (inc && !clr) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
    (!inc && !clr) |=> ($stable(cnt) && $stable(full)));
  assert_full_on_wrap_R4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(full) |-> ($past(cnt) == CNT_MAX && cnt == '0));
endmodule

// File: rtl/trace_arm_ctrl.sv
module trace_arm_ctrl (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic arm_wr,
  input  logic arm_wdata,
  input  logic wrap,
  input  logic stop_on_wrap,
  output logic armed,
  output logic session_end
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      armed       <= 1'b0;
      session_end <= 1'b0;
    end else begin
      session_end <= 1'b0;
      if (!sys_rst_n) begin
        armed <= 1'b0;
      end else if (arm_wr) begin
        armed <= arm_wdata;
      end else if (wrap && stop_on_wrap) begin
        armed       <= 1'b0;
        session_end <= 1'b1;
      end
    end
  end

  assert_end_disarms_R6: assert property (@(posedge clk) disable iff (!por_n)
    session_end |-> !armed);
  assert_end_single_R6: assert property (@(posedge clk) disable iff (!por_n)
    session_end |=> !session_end);
  assert_sysrst_disarm_R9: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> !armed);
endmodule

// File: rtl/trace_fill_counter.sv
module trace_fill_counter
  import trace_fill_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int HALF_W = 32,
  parameter int REG_W  = 8
) (
  input  logic                      clk,
  input  logic                      por_n,
  input  logic                      sys_rst_n,
  input  logic                      arm_wr,
  input  logic                      arm_wdata,
  input  logic [1:0]                align_mode,
  input  logic                      hw_valid,
  output logic                      hw_ready,
  input  logic [HALF_W-1:0]         hw_data,
  output logic                      ram_we,
  output logic [$clog2(LINES)-1:0]  ram_addr,
  output logic                      ram_half,
  output logic [HALF_W-1:0]         ram_wdata,
  output logic [REG_W-1:0]          count_reg,
  output logic                      buf_full,
  output logic                      armed,
  output logic                      session_end
);
  localparam int PTR_W = $clog2(LINES);
  localparam int CNT_W = PTR_W + 1;

  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             wrap;
  logic             arm_set;

  assign arm_set  = arm_wr && arm_wdata;
  assign hw_ready = armed && !arm_wr && sys_rst_n;
  assign accept   = hw_valid && hw_ready;

  trace_half_counter #(.LINES(LINES)) u_cnt (
    .clk  (clk),
    .por_n(por_n),
    .clr  (arm_set),
    .inc  (accept),
    .cnt  (cnt),
    .full (buf_full),
    .wrap (wrap)
  );

  trace_arm_ctrl u_arm (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .arm_wr      (arm_wr),
    .arm_wdata   (arm_wdata),
    .wrap        (wrap),
    .stop_on_wrap(stops_on_wrap(align_mode)),
    .armed       (armed),
    .session_end (session_end)
  );

  assign ram_we    = accept;
  assign ram_addr  = cnt[CNT_W-1:1];
  assign ram_half  = cnt[0];
  assign ram_wdata = hw_data;

  generate
    if (REG_W > CNT_W) begin : g_pad
      assign count_reg = {{(REG_W-CNT_W){1'b0}}, cnt};
    end else begin : g_trim
      assign count_reg = cnt[REG_W-1:0];
    end
  endgenerate

  assert_ready_armed_R2: assert property (@(posedge clk) disable iff (!por_n)
    hw_ready |-> armed);
  assert_arm_clears_R7: assert property (@(posedge clk) disable iff (!por_n)
    (arm_wr && arm_wdata && sys_rst_n) |=> (count_reg == '0 && !buf_full && armed));
  assert_wrap_keeps_arm_R5: assert property (@(posedge clk) disable iff (!por_n)
    (wrap && !stops_on_wrap(align_mode)) |=> armed);
endmodule

// File: tb/trace_fill_counter_test.sv
module trace_fill_counter_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic        arm_wr = 1'b0;
  logic        arm_wdata = 1'b0;
  logic [1:0]  align_mode = 2'b00;
  logic        hw_valid = 1'b0;
  logic [31:0] hw_data = 32'h0;
  logic        hw_ready, ram_we, ram_half, buf_full, armed, session_end;
  logic [5:0]  ram_addr;
  logic [31:0] ram_wdata;
  logic [7:0]  count_reg;
  int total = 0;
  int bad = 0;
  int ends_seen = 0;

  trace_fill_counter uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_wr(arm_wr),
    .arm_wdata(arm_wdata), .align_mode(align_mode), .hw_valid(hw_valid),
    .hw_ready(hw_ready), .hw_data(hw_data), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_half(ram_half), .ram_wdata(ram_wdata), .count_reg(count_reg),
    .buf_full(buf_full), .armed(armed), .session_end(session_end)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (session_end) ends_seen++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm_write(input logic v);
    @(negedge clk); arm_wr = 1'b1; arm_wdata = v;
    @(negedge clk); arm_wr = 1'b0;
  endtask

  task automatic push(input int n);
    @(negedge clk); hw_valid = 1'b1; hw_data = 32'hA5A50000 + n;
    repeat (n) @(posedge clk);
    @(negedge clk); hw_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 count", count_reg, 0);
    check("R1 full", buf_full, 0);
    check("R1 armed", armed, 0);
    check("R1 ready", hw_ready, 0);
  endtask

  task automatic t_ignore_disarmed;
    push(4);
    check("R2 ignored while disarmed", count_reg, 0);
  endtask

  task automatic t_basic_and_addr;
    align_mode = 2'b00;
    arm_write(1'b1);
    check("R7 arm sets", armed, 1);
    push(3);
    check("R2 count after 3", count_reg, 3);
    @(negedge clk); hw_valid = 1'b1; hw_data = 32'hDEADBEEF; #1;
    check("R3 we", ram_we, 1);
    check("R3 addr", ram_addr, 1);
    check("R3 half", ram_half, 1);
    check("R3 wdata", (ram_wdata == 32'hDEADBEEF) ? 1 : 0, 1);
    @(negedge clk); hw_valid = 1'b0;
    check("R2 count after 4", count_reg, 4);
    repeat (3) @(negedge clk);
    check("R10 idle stable", count_reg, 4);
  endtask

  task automatic t_priority;
    @(negedge clk); arm_wr = 1'b1; arm_wdata = 1'b1; hw_valid = 1'b1; #1;
    check("R7 ready low on arm write", hw_ready, 0);
    @(negedge clk); arm_wr = 1'b0; hw_valid = 1'b0;
    check("R7 clear wins", count_reg, 0);
  endtask

  task automatic t_overwrite;
    align_mode = 2'b01;
    arm_write(1'b1);
    push(127);
    check("R4 count 127", count_reg, 127);
    check("R4 not yet full", buf_full, 0);
    push(1);
    check("R4 wrap to 0", count_reg, 0);
    check("R4 full set", buf_full, 1);
    check("R5 still armed", armed, 1);
    align_mode = 2'b00;
    push(3);
    check("R5 continues", count_reg, 3);
    check("R5 addr wrapped", ram_addr, 1);
    check("R5 full kept", buf_full, 1);
  endtask

  task automatic t_sysrst;
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    check("R9 count kept", count_reg, 3);
    check("R9 full kept", buf_full, 1);
    check("R9 disarmed", armed, 0);
    push(2);
    check("R2 ignored after sysrst", count_reg, 3);
  endtask

  task automatic t_disarm;
    arm_write(1'b1);
    check("R7 full cleared", buf_full, 0);
    push(5);
    arm_write(1'b0);
    check("R8 disarmed", armed, 0);
    check("R8 count kept", count_reg, 5);
  endtask

  task automatic t_por;
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    check("R1 por count", count_reg, 0);
    check("R1 por armed", armed, 0);
  endtask

  task automatic t_begin;
    align_mode = 2'b10;
    ends_seen = 0;
    arm_write(1'b1);
    push(130);
    check("R6 count", count_reg, 0);
    check("R6 full", buf_full, 1);
    check("R6 disarmed", armed, 0);
    check("R6 one end pulse", ends_seen, 1);
    check("R6 ready low", hw_ready, 0);
    check("R1 top bit", count_reg[7], 0);
  endtask

  initial begin
    #45 por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignore_disarmed();
    t_basic_and_addr();
    t_priority();
    t_overwrite();
    t_sysrst();
    t_disarm();
    t_por();
    t_begin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule